// File: doc/BRIEF.md
# Double-Buffered Parallel DAC Register Front End

This block is the synchronous digital side of a 12-bit voltage converter that sits on an active-low parallel host bus. A host places a word on the data pins, holds chip select low, and pulses write-enable. On the trailing (rising) edge of write-enable the word enters a holding register. A separate active-low load pin copies the holding register into the DAC latch. The latch drives the converter code. Because of the two stages, a host can stage a new value and then change the output at a moment it chooses. It can also keep the load pin low so that each write passes straight through.

All host pins are asynchronous to the system clock. Each one passes through a multi-flop synchroniser before any edge is detected. The data bus is delayed one extra cycle, so the captured word is the value present just before the write edge. An active-low power-down pin blanks the code output to zero and raises a power-down output, and it leaves both registers untouched. Releasing it restores the previous code. The block also measures the host strobes in system-clock cycles and sets sticky violation flags when a setup time or pulse width is too short. Writing ones to the clear input clears those flags.

Top module: `pdac_frontend`

## Requirements
- R1: After reset, the code output is zero, the power-down output is low, the updated pulse is low and all five violation flags are zero.
- R2: A qualified write (write-enable rising while chip select is low) with the load pin held low drives the code output to the written word, bit for bit: data pin i appears on code bit i, with bit 0 the least significant.
- R3: A write-enable rising edge while chip select is high leaves the holding register unchanged, so the code output keeps its value even with the load pin low.
- R4: While the load pin is high, the DAC latch does not change, whatever is written. While the load pin is low, the latch copies the holding register.
- R5: With the load pin already low, every qualified write reaches the code output within a few cycles, one cycle after the holding register updates.
- R6: The power-down output is the synchronised inverse of the power-down pin (pin low means powered down). While it is high, the code output is zero.
- R7: Power-down alters neither register. When power-down is released, the code output shows the latched value from before power-down.
- R8: The updated output pulses for exactly one cycle each time the DAC latch value changes. It does not pulse when a load leaves the value the same.
- R9: Flag bit 0 is set when a qualified write edge comes fewer than CS_SETUP_CYC cycles after chip select went low.
- R10: Flag bit 1 is set when the data bus changed fewer than DATA_SETUP_CYC cycles before a qualified write edge.
- R11: Flag bit 2 is set when write-enable falls after a high pulse shorter than WE_HIGH_CYC cycles.
- R12: Flag bit 3 is set when the load pin rises after a low pulse shorter than LD_LOW_CYC cycles.
- R13: Flag bit 4 is set when the load pin falls while write-enable is low.
- R14: Flags are sticky. A one on bit i of the clear input clears flag i in the next cycle, and other flags are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_cs_n | input | 1 | Chip select, active low, asynchronous |
| host_we_n | input | 1 | Write strobe, active low; captures on its rising edge |
| host_ld_n | input | 1 | Load strobe, active low; latch follows holding register while low |
| host_pd_n | input | 1 | Power-down, active low |
| host_data | input | DW | Parallel data word, bit 0 least significant |
| viol_clr | input | 5 | Write-one-to-clear for the violation flags |
| dac_code | output | DW | Code to the converter, zero while powered down |
| dac_pd | output | 1 | Power-down to the converter |
| dac_updated | output | 1 | One-cycle pulse when the DAC latch changes |
| viol_flags | output | 5 | Sticky timing violation flags |

## Verification
The hardest conditions to create are the timing violations that must be isolated to one flag. Each one needs a single strobe relationship to be one cycle too short while every other setup and width rule is still met. Otherwise a neighbouring flag fires as well. The bench builds each violation from whole-cycle pin moves at the falling clock edge. Examples are chip select dropping one cycle before write-enable rises, and write-enable returning low after one high cycle. The bench then compares the full flag vector against a single expected bit and clears it before the next case. A second difficult condition is power-down with a pending write held back by the load pin. The bench stages a word during power-down and shows that release restores the old code, and that only a later load exposes the new one.

// File: rtl/pdac_pkg.sv
`timescale 1ns/1ps
package pdac_pkg;
   // Violation flag positions (the bench and host software decode these)
   localparam int unsigned V_CS_SETUP  = 0;
   localparam int unsigned V_DAT_SETUP = 1;
   localparam int unsigned V_WE_WIDTH  = 2;
   localparam int unsigned V_LD_WIDTH  = 3;
   localparam int unsigned V_LD_ORDER  = 4;
   localparam int unsigned NUM_VIOL    = 5;

   // Number of pins besides the data bus that cross into the clock domain
   localparam int unsigned NUM_CTRL    = 4;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/pdac_sync.sv
`timescale 1ns/1ps
module pdac_sync #(
   parameter int unsigned W      = 16,
   parameter int unsigned STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pdac_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= {STAGES{RST_VAL}};
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/pdac_strobe.sv
`timescale 1ns/1ps
module pdac_strobe #(
   parameter int unsigned DW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_s,
   input  logic          we_s,
   input  logic          ld_s,
   input  logic [DW-1:0] dat_s,
   output logic          wr_stb,
   output logic          we_fall,
   output logic          ld_fall,
   output logic          ld_rise,
   output logic          dat_chg,
   output logic [DW-1:0] dat_q
);
   logic cs_q, we_q, ld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q  <= 1'b1;
         we_q  <= 1'b1;
         ld_q  <= 1'b1;
         dat_q <= '0;
      end else begin
         cs_q  <= cs_s;
         we_q  <= we_s;
         ld_q  <= ld_s;
         dat_q <= dat_s;
      end
   end

   // Trailing edge of the write strobe, qualified by select at that edge
   assign wr_stb  = we_s & ~we_q & ~cs_q;
   assign we_fall = ~we_s & we_q;
   assign ld_fall = ~ld_s & ld_q;
   assign ld_rise = ld_s & ~ld_q;
   assign dat_chg = (dat_s != dat_q);
endmodule

// File: rtl/pdac_regs.sv
`timescale 1ns/1ps
module pdac_regs #(
   parameter int unsigned DW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_stb,
   input  logic          ld_act,
   input  logic [DW-1:0] dat_in,
   output logic [DW-1:0] hold_q,
   output logic [DW-1:0] lat_q,
   output logic          upd
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         lat_q  <= '0;
         upd    <= 1'b0;
      end else begin
         if (wr_stb) hold_q <= dat_in;
         if (ld_act) lat_q  <= hold_q;
         upd <= ld_act && (hold_q != lat_q);
      end
   end
endmodule

// File: rtl/pdac_timing.sv
`timescale 1ns/1ps
module pdac_timing
   import pdac_pkg::*;
#(
   parameter int unsigned CS_SETUP_CYC   = 2,
   parameter int unsigned DATA_SETUP_CYC = 2,
   parameter int unsigned WE_HIGH_CYC    = 2,
   parameter int unsigned LD_LOW_CYC     = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cs_s,
   input  logic                we_s,
   input  logic                ld_s,
   input  logic                wr_stb,
   input  logic                we_fall,
   input  logic                ld_fall,
   input  logic                ld_rise,
   input  logic                dat_chg,
   input  logic [NUM_VIOL-1:0] clr,
   output logic [NUM_VIOL-1:0] flags
);
   localparam int unsigned NCNT = 4;
   localparam int unsigned LMAX = max2(max2(CS_SETUP_CYC, DATA_SETUP_CYC),
                                       max2(WE_HIGH_CYC, LD_LOW_CYC));
   localparam int unsigned CW   = (LMAX < 1) ? 1 : $clog2(LMAX + 1);
   localparam int unsigned LIM [NCNT] = '{CS_SETUP_CYC, DATA_SETUP_CYC,
                                          WE_HIGH_CYC, LD_LOW_CYC};

   generate
      if (LMAX < 1) begin : g_bad_lim
         $error("pdac_timing: at least one timing limit must be non-zero");
      end
   endgenerate

   logic [NCNT-1:0]         run;
   logic [NCNT-1:0]         short;
   logic [NCNT-1:0][CW-1:0] cnt;
   logic [NUM_VIOL-1:0]     set;

   // 0: select low, 1: data stable, 2: write strobe high, 3: load low
   assign run = {~ld_s, we_s, ~dat_chg, ~cs_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else begin
         for (int i = 0; i < NCNT; i++) begin
            if (!run[i])                  cnt[i] <= '0;
            else if (cnt[i] < CW'(LMAX))  cnt[i] <= cnt[i] + 1'b1;
         end
      end
   end

   always_comb begin
      for (int i = 0; i < NCNT; i++) short[i] = (cnt[i] < CW'(LIM[i]));
   end

   always_comb begin
      set              = '0;
      set[V_CS_SETUP]  = wr_stb  & short[0];
      set[V_DAT_SETUP] = wr_stb  & short[1];
      set[V_WE_WIDTH]  = we_fall & short[2];
      set[V_LD_WIDTH]  = ld_rise & short[3];
      set[V_LD_ORDER]  = ld_fall & ~we_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags <= '0;
      else        flags <= (flags & ~clr) | set;
   end
endmodule

// File: rtl/pdac_frontend.sv
`timescale 1ns/1ps
module pdac_frontend
   import pdac_pkg::*;
#(
   parameter int unsigned DW             = 12,
   parameter int unsigned SYNC_STAGES    = 2,
   parameter int unsigned CS_SETUP_CYC   = 2,
   parameter int unsigned DATA_SETUP_CYC = 2,
   parameter int unsigned WE_HIGH_CYC    = 2,
   parameter int unsigned LD_LOW_CYC     = 2,
   parameter bit          OUT_REG        = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                host_cs_n,
   input  logic                host_we_n,
   input  logic                host_ld_n,
   input  logic                host_pd_n,
   input  logic [DW-1:0]       host_data,
   input  logic [NUM_VIOL-1:0] viol_clr,
   output logic [DW-1:0]       dac_code,
   output logic                dac_pd,
   output logic                dac_updated,
   output logic [NUM_VIOL-1:0] viol_flags
);
   localparam int unsigned SW = DW + NUM_CTRL;
   localparam logic [SW-1:0] SYNC_RST = {{NUM_CTRL{1'b1}}, {DW{1'b0}}};

   generate
      if (DW < 1 || DW > 32) begin : g_bad_dw
         $error("pdac_frontend: DW must lie in 1..32");
      end
   endgenerate

   logic [SW-1:0] pins_s;
   logic          cs_s, we_s, ld_s, pd_s;
   logic [DW-1:0] dat_s, dat_q;
   logic          wr_stb, we_fall, ld_fall, ld_rise, dat_chg, ld_act;
   logic [DW-1:0] hold_q, lat_q;

   pdac_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({host_pd_n, host_ld_n, host_we_n, host_cs_n, host_data}),
      .q     (pins_s)
   );

   assign {pd_s, ld_s, we_s, cs_s, dat_s} = pins_s;
   assign ld_act = ~ld_s;

   pdac_strobe #(.DW(DW)) u_strobe (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs_s    (cs_s),
      .we_s    (we_s),
      .ld_s    (ld_s),
      .dat_s   (dat_s),
      .wr_stb  (wr_stb),
      .we_fall (we_fall),
      .ld_fall (ld_fall),
      .ld_rise (ld_rise),
      .dat_chg (dat_chg),
      .dat_q   (dat_q)
   );

   pdac_regs #(.DW(DW)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_stb (wr_stb),
      .ld_act (ld_act),
      .dat_in (dat_q),
      .hold_q (hold_q),
      .lat_q  (lat_q),
      .upd    (dac_updated)
   );

   pdac_timing #(
      .CS_SETUP_CYC   (CS_SETUP_CYC),
      .DATA_SETUP_CYC (DATA_SETUP_CYC),
      .WE_HIGH_CYC    (WE_HIGH_CYC),
      .LD_LOW_CYC     (LD_LOW_CYC)
   ) u_timing (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs_s    (cs_s),
      .we_s    (we_s),
      .ld_s    (ld_s),
      .wr_stb  (wr_stb),
      .we_fall (we_fall),
      .ld_fall (ld_fall),
      .ld_rise (ld_rise),
      .dat_chg (dat_chg),
      .clr     (viol_clr),
      .flags   (viol_flags)
   );

   generate
      if (OUT_REG) begin : g_out_reg
         logic          pd_r;
         logic [DW-1:0] code_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pd_r   <= 1'b0;
               code_r <= '0;
            end else begin
               pd_r   <= ~pd_s;
               code_r <= pd_s ? lat_q : '0;
            end
         end
         assign dac_pd   = pd_r;
         assign dac_code = code_r;
      end else begin : g_out_comb
         assign dac_pd   = ~pd_s;
         assign dac_code = pd_s ? lat_q : '0;
      end
   endgenerate
endmodule

// File: rtl/pdac_frontend_chk.sv
`timescale 1ns/1ps
module pdac_frontend_chk
   import pdac_pkg::*;
#(
   parameter int unsigned DW = 12
) (
   input logic                clk,
   input logic                rst_n,
   input logic [DW-1:0]       dac_code,
   input logic                dac_pd,
   input logic                dac_updated,
   input logic [NUM_VIOL-1:0] viol_flags,
   input logic [NUM_VIOL-1:0] viol_clr,
   input logic [DW-1:0]       hold_q,
   input logic [DW-1:0]       lat_q,
   input logic                wr_stb,
   input logic                ld_act
);
   assert_pd_blanks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dac_pd |-> (dac_code == '0));

   assert_latch_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_act |=> $stable(lat_q));

   assert_hold_write_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> $stable(hold_q));

   assert_upd_on_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
      dac_updated |-> !$stable(lat_q));

   assert_change_gives_upd_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(lat_q) |-> dac_updated);

   assert_flags_sticky_R14: assert property (@(posedge clk) disable iff (!rst_n)
      ((viol_flags & $past(viol_flags & ~viol_clr)) == $past(viol_flags & ~viol_clr)));
endmodule

bind pdac_frontend pdac_frontend_chk #(.DW(DW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .dac_code    (dac_code),
   .dac_pd      (dac_pd),
   .dac_updated (dac_updated),
   .viol_flags  (viol_flags),
   .viol_clr    (viol_clr),
   .hold_q      (hold_q),
   .lat_q       (lat_q),
   .wr_stb      (wr_stb),
   .ld_act      (ld_act)
);

// File: tb/test_pdac_frontend.sv
`timescale 1ns/1ps
module test_pdac_frontend;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1, we_n = 1'b1, ld_n = 1'b1, pd_n = 1'b1;
   logic [11:0] dat = '0;
   logic [4:0]  clr = '0;
   logic [11:0] code;
   logic        pd_o, upd;
   logic [4:0]  flags;

   int vec = 0, mis = 0, upd_cnt = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pdac_frontend i_pdac_frontend (
      .clk(clk), .rst_n(rst_n),
      .host_cs_n(cs_n), .host_we_n(we_n), .host_ld_n(ld_n), .host_pd_n(pd_n),
      .host_data(dat), .viol_clr(clr),
      .dac_code(code), .dac_pd(pd_o), .dac_updated(upd), .viol_flags(flags)
   );

   always @(negedge clk) if (rst_n && upd) upd_cnt++;

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vec++;
      if (act !== exp) begin
         mis++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Well-timed bus write; cs_on=0 pulses the strobe with select high
   task automatic wr(input logic [11:0] d, input bit cs_on);
      dat = d; cs_n = ~cs_on;
      step(2); we_n = 1'b0;
      step(3); we_n = 1'b1;
      step(2); cs_n = 1'b1;
      step(4);
   endtask

   task automatic clear_all();
      clr = 5'h1F; step(1); clr = '0; step(1);
   endtask

   initial begin
      int base;
      step(3); rst_n = 1'b1; step(5);

      // R1: reset state
      chk("R1 code", code, 0);
      chk("R1 pd", pd_o, 0);
      chk("R1 upd", upd, 0);
      chk("R1 flags", flags, 0);

      // R2: walking one with load held low, bit order D0 = LSB
      ld_n = 1'b0; step(4);
      for (int i = 0; i < 12; i++) begin
         wr(12'(1 << i), 1'b1);
         chk($sformatf("R2 bit%0d", i), code, 32'(1 << i));
      end
      // R5: pass-through for an arithmetic sweep
      for (int k = 0; k < 16; k++) begin
         wr(12'((k * 1237 + 5) & 12'hFFF), 1'b1);
         chk($sformatf("R5 k%0d", k), code, 32'((k * 1237 + 5) & 12'hFFF));
      end
      // R8: one pulse per distinct latch value (28 so far)
      chk("R8 count", upd_cnt, 28);
      base = upd_cnt;
      wr(code, 1'b1);
      chk("R8 same value no pulse", upd_cnt, base);

      // R3: strobe with select high is ignored
      base = code;
      wr(12'hABC, 1'b0);
      chk("R3 deselected", code, base);

      // R4: load high blocks the latch, load pulse transfers it
      ld_n = 1'b1; step(4);
      wr(12'h5A5, 1'b1);
      chk("R4 blocked", code, base);
      base = upd_cnt;
      ld_n = 1'b0; step(3); ld_n = 1'b1; step(5);
      chk("R4 loaded", code, 12'h5A5);
      chk("R8 load pulse", upd_cnt, base + 1);

      // R6 / R7: power-down blanks, keeps latch, staged word waits for load
      pd_n = 1'b0; step(4);
      chk("R6 pd out", pd_o, 1);
      chk("R6 code blank", code, 0);
      wr(12'h123, 1'b1);
      chk("R6 code blank after write", code, 0);
      pd_n = 1'b1; step(4);
      chk("R6 pd released", pd_o, 0);
      chk("R7 restored", code, 12'h5A5);
      ld_n = 1'b0; step(3); ld_n = 1'b1; step(5);
      chk("R7 staged word loaded", code, 12'h123);
      chk("R9 R10 R11 R12 R13 no flags on clean traffic", flags, 0);

      // R9: select falls one cycle before the write edge
      dat = 12'h0F0; step(5);
      we_n = 1'b0; step(3);
      cs_n = 1'b0; step(1);
      we_n = 1'b1; step(2); cs_n = 1'b1; step(4);
      chk("R9 cs setup", flags, 5'b00001);
      clear_all();
      chk("R14 cleared", flags, 0);

      // R10: data changes one cycle before the write edge
      cs_n = 1'b0; dat = 12'h111; step(2);
      we_n = 1'b0; step(3);
      dat = 12'h222; step(1);
      we_n = 1'b1; step(2); cs_n = 1'b1; step(4);
      chk("R10 data setup", flags, 5'b00010);
      clear_all();

      // R11: write strobe high for only one cycle
      cs_n = 1'b0; step(3);
      we_n = 1'b0; step(3); we_n = 1'b1; step(1);
      we_n = 1'b0; step(3); we_n = 1'b1; step(2);
      cs_n = 1'b1; step(4);
      chk("R11 we width", flags, 5'b00100);
      clear_all();

      // R12: load low for only one cycle
      ld_n = 1'b0; step(1); ld_n = 1'b1; step(5);
      chk("R12 ld width", flags, 5'b01000);

      // R13: load falls while write strobe low (select high, no write)
      we_n = 1'b0; step(2);
      ld_n = 1'b0; step(3); ld_n = 1'b1; step(2);
      we_n = 1'b1; step(4);
      chk("R13 ld order", flags, 5'b11000);

      // R14: clear one bit only
      clr = 5'b01000; step(1); clr = '0; step(1);
      chk("R14 partial clear", flags, 5'b10000);
      clear_all();
      chk("R14 all clear", flags, 0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         vec++; mis++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
         $finish;
      end
   end
endmodule